// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a transmit command queue and a bit-level I2C engine. Each queued command word carries one data byte plus three control flags: direction, stop-after and forced-restart. The sequencer reads the word at the head of the queue and combines it with a target setup word that selects 7-bit or 10-bit addressing, a general-call broadcast or a START BYTE preamble. From these it decides when the engine must produce START, the address phase, RESTART, a data byte and STOP. It asks the engine for one operation at a time and waits for the completion pulse. It checks the acknowledge bit returned for every byte it sends, and it forwards each byte it reads to a receive queue.

Some sequences cannot be carried out when the restart-enable input is low, and some are never legal. When the sequencer meets one of these, or when a target fails to acknowledge, arbitration is lost or software asks it to stop, it records the reason in a sticky cause vector. It then releases the bus and holds the command queue flushed until software clears the cause.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset no operation is requested (op_valid low), abort_cause is zero, and cmd_flush and abort_pend are low.
- R2: Operation codes on op_code are START=0, RESTART=1, STOP=2, WRITE=3 and READ=4. START, RESTART and STOP carry a zero byte and a zero NACK flag. Command words use bits 7:0 for data, bit 8 for read (1) or write (0), bit 9 for stop-after and bit 10 for forced restart. The target setup word uses bits 9:0 for the address, bit 10 for the special select (0 = general call, 1 = START BYTE), bit 11 to enable the special command and bit 12 for 10-bit mode. On a free bus, a 7-bit command is sent as START, then WRITE of {addr[6:0], dir}, then the data operation.
- R3: A command with the same direction as the previous one, sent without a STOP in between and without the force flag, produces only its data operation.
- R4: A change of direction, or bit 10 of the command word set, produces RESTART and a new address byte before the data operation.
- R5: When bit 9 is set, STOP follows the byte's operation, and the next command begins with START.
- R6: A read command produces READ with the NACK flag equal to the command's stop bit, and the returned byte appears on rx_data with rx_push.
- R7: In 10-bit mode the header is {11110, addr[9:8], 0} followed by addr[7:0]. A read then adds RESTART and {11110, addr[9:8], 1}.
- R8: In general-call mode the header byte is 0x00. A read command sets cause bit 4 and issues no bus operation.
- R9: In START BYTE mode the sequencer sends 0x01, which the target must NACK, then RESTART, then the normal address. An ACK to 0x01 sets cause bit 7 and issues STOP.
- R10: With restart_en low, the following abort: a restart needed inside a held transfer (cause bit 11), a 10-bit read (cause bit 10) and a START BYTE (cause bit 9). The last two abort before any bus operation.
- R11: A NACK sets a cause bit and then issues STOP. The bit is 0 for the 7-bit address, 1 for the first 10-bit byte, 2 for the second 10-bit byte, 3 for write data and 5 for the general call. Causes are sticky, and cmd_flush stays high until abort_clr.
- R12: Arbitration loss on any operation sets cause bit 12 with no STOP. The bus counts as released, so the next transfer starts with START.
- R13: abort_req sets abort_pend only while enable is high. The sequencer then issues STOP, sets cause bit 16 and clears abort_pend when that STOP completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enabled; gates new commands and abort requests |
| restart_en | input | 1 | Allows RESTART to be generated |
| tgt_cfg | input | 13 | Target setup: address, special select, special enable, 10-bit mode |
| cmd_avail | input | 1 | Command queue holds at least one word |
| cmd_word | input | 11 | Word at the head of the command queue |
| cmd_pop | output | 1 | Removes the head word |
| cmd_flush | output | 1 | Holds the command queue empty while an abort is recorded |
| op_valid | output | 1 | Operation request to the bit engine |
| op_code | output | 3 | Requested operation |
| op_byte | output | 8 | Byte to send for WRITE |
| op_nack | output | 1 | For READ, NACK the received byte |
| op_done | input | 1 | Engine completion pulse |
| op_ack_n | input | 1 | Acknowledge bit seen after a WRITE (1 = NACK) |
| op_arb_lost | input | 1 | Arbitration lost during the operation |
| op_rdata | input | 8 | Byte received by READ |
| rx_push | output | 1 | Writes rx_data to the receive queue |
| rx_data | output | 8 | Received byte |
| abort_req | input | 1 | Software stop request pulse |
| abort_clr | input | 1 | Clears the cause vector and releases the queue |
| abort_pend | output | 1 | Stop request pending |
| abort_active | output | 1 | Some cause bit is set |
| abort_cause | output | 17 | Sticky abort cause vector |

## Verification
Some properties are checked on every cycle. Once set, cause bits stay set until cleared. A flushed queue is never popped. While an abort is recorded the only operation requested is STOP. START is never requested while the bus is held. A pending stop request only appears while the controller is enabled. A push to the receive queue only happens when the head command is a read. The bench scenarios are the only place the exact operation sequences are checked: where RESTART appears, which header bytes are sent in each addressing mode, which cause bit each NACK maps to and what the restart-disabled mode rejects.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
   typedef enum logic [2:0] {
      OP_START   = 3'd0,
      OP_RESTART = 3'd1,
      OP_STOP    = 3'd2,
      OP_WRITE   = 3'd3,
      OP_READ    = 3'd4
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_HDR, ST_SBYTE, ST_SB_RS, ST_ADDR1, ST_ADDR2,
      ST_ADDR_RS, ST_ADDR3, ST_DATA, ST_STOP, ST_HALT
   } seq_state_e;

   // cause bit positions
   localparam int CB_ADDR7    = 0;
   localparam int CB_TEN1     = 1;
   localparam int CB_TEN2     = 2;
   localparam int CB_DATA     = 3;
   localparam int CB_GC_READ  = 4;
   localparam int CB_GC_NOACK = 5;
   localparam int CB_SB_ACKED = 7;
   localparam int CB_NORS_SB  = 9;
   localparam int CB_NORS_TEN = 10;
   localparam int CB_NORS_DIR = 11;
   localparam int CB_ARB      = 12;
   localparam int CB_USER     = 16;
   localparam int CAUSE_MIN_W = 17;
endpackage

// File: rtl/i2cseq_hdr_rules.sv
module i2cseq_hdr_rules #(
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 10,
   parameter int CAUSE_W    = 17,
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic [ADDR_W+2:0]  tgt_cfg,
   input  logic               restart_en,
   input  logic               cmd_rd,
   input  logic               cmd_force,
   input  logic               bus_held,
   input  logic               last_rd,
   output logic               need_hdr,
   output logic               gc_mode,
   output logic               sb_mode,
   output logic               ten_mode,
   output logic [CAUSE_W-1:0] violation,
   output logic [BYTE_W-1:0]  hdr_first,
   output logic [BYTE_W-1:0]  hdr_low,
   output logic [BYTE_W-1:0]  hdr_rd10
);
   import i2cseq_pkg::*;

   localparam int SEL_BIT  = ADDR_W;
   localparam int SPEC_BIT = ADDR_W + 1;
   localparam int TEN_BIT  = ADDR_W + 2;

   logic [ADDR_W-1:0] addr;
   logic              dir_change;
   logic [4:0]        ten_prefix;

   assign addr       = tgt_cfg[ADDR_W-1:0];
   assign gc_mode    = tgt_cfg[SPEC_BIT] & ~tgt_cfg[SEL_BIT];
   assign sb_mode    = tgt_cfg[SPEC_BIT] &  tgt_cfg[SEL_BIT];
   assign ten_prefix = 5'b11110;

   generate
      if (TEN_BIT_EN) begin : g_ten
         assign ten_mode = tgt_cfg[TEN_BIT] & ~gc_mode;
      end else begin : g_seven
         assign ten_mode = 1'b0;
      end
   endgenerate

   assign dir_change = bus_held & (cmd_rd != last_rd);
   assign need_hdr   = ~bus_held | dir_change | cmd_force;

   assign hdr_low  = addr[7:0];
   assign hdr_rd10 = {ten_prefix, addr[9:8], 1'b1};

   always_comb begin
      if (gc_mode)       hdr_first = '0;
      else if (ten_mode) hdr_first = {ten_prefix, addr[9:8], 1'b0};
      else               hdr_first = {addr[6:0], cmd_rd};
   end

   always_comb begin
      violation              = '0;
      violation[CB_GC_READ]  = gc_mode & cmd_rd;
      violation[CB_NORS_SB]  = need_hdr & sb_mode & ~restart_en;
      violation[CB_NORS_TEN] = need_hdr & ten_mode & cmd_rd & ~restart_en;
      violation[CB_NORS_DIR] = bus_held & (dir_change | cmd_force) & ~restart_en;
   end
endmodule

// File: rtl/i2cseq_abort_src.sv
module i2cseq_abort_src #(
   parameter int CAUSE_W = 17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [CAUSE_W-1:0] set_vec,
   input  logic               clr,
   input  logic               user_req,
   input  logic               user_done,
   output logic [CAUSE_W-1:0] cause,
   output logic               active,
   output logic               user_pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause     <= '0;
         user_pend <= 1'b0;
      end else begin
         cause <= (clr ? '0 : cause) | set_vec;
         if (user_done)               user_pend <= 1'b0;
         else if (user_req && enable) user_pend <= 1'b1;
      end
   end

   assign active = |cause;

   // R11: recorded causes are never lost without a clear
   a_r11_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((cause & $past(cause)) == $past(cause)));

   // R13: a stop request can only become pending while enabled
   a_r13_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_pend) |-> $past(enable));
endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm #(
   parameter int BYTE_W  = 8,
   parameter int CAUSE_W = 17,
   localparam int CMD_W  = BYTE_W + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               cmd_avail,
   input  logic [CMD_W-1:0]   cmd_word,
   output logic               cmd_pop,
   output logic               op_valid,
   output logic [2:0]         op_code,
   output logic [BYTE_W-1:0]  op_byte,
   output logic               op_nack,
   input  logic               op_done,
   input  logic               op_ack_n,
   input  logic               op_arb_lost,
   output logic               rx_push,
   input  logic               need_hdr,
   input  logic               gc_mode,
   input  logic               sb_mode,
   input  logic               ten_mode,
   input  logic [CAUSE_W-1:0] violation,
   input  logic [BYTE_W-1:0]  hdr_first,
   input  logic [BYTE_W-1:0]  hdr_low,
   input  logic [BYTE_W-1:0]  hdr_rd10,
   input  logic               user_pend,
   input  logic               abort_active,
   output logic               bus_held,
   output logic               last_rd,
   output logic [CAUSE_W-1:0] set_vec,
   output logic               user_done
);
   import i2cseq_pkg::*;

   localparam int RD_BIT   = BYTE_W;
   localparam int STOP_BIT = BYTE_W + 1;

   seq_state_e         state, nxt;
   logic               held_nxt, lastrd_nxt, stop_abort, stop_abort_nxt;
   logic [CAUSE_W-1:0] fail_vec;
   logic               cmd_rd, cmd_stop;

   assign cmd_rd   = cmd_word[RD_BIT];
   assign cmd_stop = cmd_word[STOP_BIT];

   // operation request
   always_comb begin
      op_valid = 1'b1;
      op_code  = OP_WRITE;
      op_byte  = '0;
      op_nack  = 1'b0;
      case (state)
         ST_HDR:     op_code = bus_held ? OP_RESTART : OP_START;
         ST_SBYTE:   op_byte = 8'h01;
         ST_SB_RS,
         ST_ADDR_RS: op_code = OP_RESTART;
         ST_ADDR1:   op_byte = hdr_first;
         ST_ADDR2:   op_byte = hdr_low;
         ST_ADDR3:   op_byte = hdr_rd10;
         ST_DATA: begin
            if (cmd_rd) begin
               op_code = OP_READ;
               op_nack = cmd_stop;
            end else begin
               op_byte = cmd_word[BYTE_W-1:0];
            end
         end
         ST_STOP:    op_code = OP_STOP;
         default: begin
            op_valid = 1'b0;
            op_code  = OP_START;
         end
      endcase
   end

   // sequencing decisions
   always_comb begin
      nxt            = state;
      held_nxt       = bus_held;
      lastrd_nxt     = last_rd;
      stop_abort_nxt = stop_abort;
      set_vec        = '0;
      fail_vec       = '0;
      cmd_pop        = 1'b0;
      rx_push        = 1'b0;
      user_done      = 1'b0;
      case (state)
         ST_IDLE: begin
            if (user_pend) begin
               set_vec[CB_USER] = 1'b1;
               stop_abort_nxt   = 1'b1;
               nxt              = ST_STOP;
            end else if (enable && cmd_avail) begin
               if (|violation) begin
                  set_vec        = violation;
                  stop_abort_nxt = 1'b1;
                  nxt            = bus_held ? ST_STOP : ST_HALT;
               end else begin
                  nxt = need_hdr ? ST_HDR : ST_DATA;
               end
            end
         end
         ST_HALT: if (!abort_active) nxt = ST_IDLE;
         default: begin
            if (op_done && op_arb_lost) begin
               set_vec[CB_ARB] = 1'b1;
               held_nxt        = 1'b0;
               user_done       = (state == ST_STOP) && stop_abort;
               nxt             = ST_HALT;
            end else if (op_done) begin
               case (state)
                  ST_HDR: begin
                     held_nxt = 1'b1;
                     nxt      = sb_mode ? ST_SBYTE : ST_ADDR1;
                  end
                  ST_SBYTE: begin
                     if (!op_ack_n) fail_vec[CB_SB_ACKED] = 1'b1;
                     else           nxt = ST_SB_RS;
                  end
                  ST_SB_RS:   nxt = ST_ADDR1;
                  ST_ADDR1: begin
                     if (op_ack_n) begin
                        if (gc_mode)       fail_vec[CB_GC_NOACK] = 1'b1;
                        else if (ten_mode) fail_vec[CB_TEN1]     = 1'b1;
                        else               fail_vec[CB_ADDR7]    = 1'b1;
                     end else begin
                        nxt = ten_mode ? ST_ADDR2 : ST_DATA;
                     end
                  end
                  ST_ADDR2: begin
                     if (op_ack_n) fail_vec[CB_TEN2] = 1'b1;
                     else          nxt = cmd_rd ? ST_ADDR_RS : ST_DATA;
                  end
                  ST_ADDR_RS: nxt = ST_ADDR3;
                  ST_ADDR3: begin
                     if (op_ack_n) fail_vec[CB_TEN1] = 1'b1;
                     else          nxt = ST_DATA;
                  end
                  ST_DATA: begin
                     if (!cmd_rd && op_ack_n) begin
                        fail_vec[CB_DATA] = 1'b1;
                     end else begin
                        cmd_pop    = 1'b1;
                        rx_push    = cmd_rd;
                        lastrd_nxt = cmd_rd;
                        nxt        = cmd_stop ? ST_STOP : ST_IDLE;
                     end
                  end
                  ST_STOP: begin
                     held_nxt       = 1'b0;
                     user_done      = stop_abort;
                     stop_abort_nxt = 1'b0;
                     nxt            = stop_abort ? ST_HALT : ST_IDLE;
                  end
                  default: nxt = ST_IDLE;
               endcase
               if (|fail_vec) begin
                  set_vec        = fail_vec;
                  stop_abort_nxt = 1'b1;
                  nxt            = ST_STOP;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bus_held   <= 1'b0;
         last_rd    <= 1'b0;
         stop_abort <= 1'b0;
      end else begin
         state      <= nxt;
         bus_held   <= held_nxt;
         last_rd    <= lastrd_nxt;
         stop_abort <= stop_abort_nxt;
      end
   end

   // R2: START is only requested on a free bus
   a_r2_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_START) |-> !bus_held);

   // R3: a pop only happens when the queue holds a word
   a_r3_pop_needs_avail: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pop |-> cmd_avail);

   // R6: received bytes are only pushed for read commands
   a_r6_push_for_read: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> cmd_word[RD_BIT]);
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 10,
   parameter int CAUSE_W    = 17,
   parameter bit TEN_BIT_EN = 1'b1,
   localparam int CMD_W     = BYTE_W + 3,
   localparam int CFG_W     = ADDR_W + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               restart_en,
   input  logic [CFG_W-1:0]   tgt_cfg,
   input  logic               cmd_avail,
   input  logic [CMD_W-1:0]   cmd_word,
   output logic               cmd_pop,
   output logic               cmd_flush,
   output logic               op_valid,
   output logic [2:0]         op_code,
   output logic [BYTE_W-1:0]  op_byte,
   output logic               op_nack,
   input  logic               op_done,
   input  logic               op_ack_n,
   input  logic               op_arb_lost,
   input  logic [BYTE_W-1:0]  op_rdata,
   output logic               rx_push,
   output logic [BYTE_W-1:0]  rx_data,
   input  logic               abort_req,
   input  logic               abort_clr,
   output logic               abort_pend,
   output logic               abort_active,
   output logic [CAUSE_W-1:0] abort_cause
);
   import i2cseq_pkg::*;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("i2c_cmd_seq: BYTE_W must be 8");
      end
      if (ADDR_W != 10) begin : g_bad_addr
         $error("i2c_cmd_seq: ADDR_W must be 10");
      end
      if (CAUSE_W < CAUSE_MIN_W) begin : g_bad_cause
         $error("i2c_cmd_seq: CAUSE_W too narrow");
      end
   endgenerate

   logic               need_hdr, gc_mode, sb_mode, ten_mode;
   logic               bus_held, last_rd, user_done;
   logic [CAUSE_W-1:0] violation, set_vec;
   logic [BYTE_W-1:0]  hdr_first, hdr_low, hdr_rd10;

   i2cseq_hdr_rules #(
      .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .TEN_BIT_EN(TEN_BIT_EN)
   ) u_rules (
      .tgt_cfg   (tgt_cfg),
      .restart_en(restart_en),
      .cmd_rd    (cmd_word[BYTE_W]),
      .cmd_force (cmd_word[BYTE_W+2]),
      .bus_held  (bus_held),
      .last_rd   (last_rd),
      .need_hdr  (need_hdr),
      .gc_mode   (gc_mode),
      .sb_mode   (sb_mode),
      .ten_mode  (ten_mode),
      .violation (violation),
      .hdr_first (hdr_first),
      .hdr_low   (hdr_low),
      .hdr_rd10  (hdr_rd10)
   );

   i2cseq_abort_src #(.CAUSE_W(CAUSE_W)) u_abort (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .set_vec  (set_vec),
      .clr      (abort_clr),
      .user_req (abort_req),
      .user_done(user_done),
      .cause    (abort_cause),
      .active   (abort_active),
      .user_pend(abort_pend)
   );

   i2cseq_fsm #(.BYTE_W(BYTE_W), .CAUSE_W(CAUSE_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .cmd_avail   (cmd_avail),
      .cmd_word    (cmd_word),
      .cmd_pop     (cmd_pop),
      .op_valid    (op_valid),
      .op_code     (op_code),
      .op_byte     (op_byte),
      .op_nack     (op_nack),
      .op_done     (op_done),
      .op_ack_n    (op_ack_n),
      .op_arb_lost (op_arb_lost),
      .rx_push     (rx_push),
      .need_hdr    (need_hdr),
      .gc_mode     (gc_mode),
      .sb_mode     (sb_mode),
      .ten_mode    (ten_mode),
      .violation   (violation),
      .hdr_first   (hdr_first),
      .hdr_low     (hdr_low),
      .hdr_rd10    (hdr_rd10),
      .user_pend   (abort_pend),
      .abort_active(abort_active),
      .bus_held    (bus_held),
      .last_rd     (last_rd),
      .set_vec     (set_vec),
      .user_done   (user_done)
   );

   assign cmd_flush = abort_active;
   assign rx_data   = op_rdata;

   // R11: a flushed queue is never popped
   a_r11_flush_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_flush |-> !cmd_pop);

   // R11: while a cause is recorded only STOP may be requested
   a_r11_abort_only_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_active && op_valid) |-> (op_code == 3'd2));
endmodule

// File: tb/i2c_cmd_seq_bench.sv
module i2c_cmd_seq_bench;
   localparam logic [2:0] C_START = 3'd0, C_RS = 3'd1, C_STOP = 3'd2, C_WR = 3'd3, C_RD = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b1, restart_en = 1'b1;
   logic [12:0] tgt_cfg = 13'h055;
   logic        cmd_avail, cmd_pop, cmd_flush;
   logic [10:0] cmd_word;
   logic        op_valid, op_nack;
   logic [2:0]  op_code;
   logic [7:0]  op_byte;
   logic        op_done = 1'b0, op_ack_n = 1'b0, op_arb_lost = 1'b0;
   logic [7:0]  op_rdata = 8'h00;
   logic        rx_push;
   logic [7:0]  rx_data;
   logic        abort_req = 1'b0, abort_clr = 1'b0;
   logic        abort_pend, abort_active;
   logic [16:0] abort_cause;

   always #2 clk = ~clk;

   i2c_cmd_seq u_i2c_cmd_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable), .restart_en(restart_en),
      .tgt_cfg(tgt_cfg), .cmd_avail(cmd_avail), .cmd_word(cmd_word),
      .cmd_pop(cmd_pop), .cmd_flush(cmd_flush), .op_valid(op_valid),
      .op_code(op_code), .op_byte(op_byte), .op_nack(op_nack),
      .op_done(op_done), .op_ack_n(op_ack_n), .op_arb_lost(op_arb_lost),
      .op_rdata(op_rdata), .rx_push(rx_push), .rx_data(rx_data),
      .abort_req(abort_req), .abort_clr(abort_clr), .abort_pend(abort_pend),
      .abort_active(abort_active), .abort_cause(abort_cause)
   );

   // command queue model
   logic [10:0] q [0:15];
   logic [4:0]  q_head = 5'd0, q_tail = 5'd0;
   assign cmd_avail = (q_head != q_tail);
   assign cmd_word  = q[q_head[3:0]];
   always @(posedge clk) begin
      if (cmd_flush)    q_head <= q_tail;
      else if (cmd_pop) q_head <= q_head + 5'd1;
   end

   // bit-engine model: 3 cycles per operation, responses by op index
   logic [11:0] olog [0:255];
   logic        nack_map [0:255];
   logic        arb_map [0:255];
   int          nops = 0, cur_idx = 0, eng_cnt = 0;
   logic [7:0]  rxlog [0:63];
   int          rx_cnt = 0;

   always @(posedge clk) begin
      op_done <= 1'b0;
      if (!rst_n) begin
         eng_cnt <= 0;
      end else if (eng_cnt != 0) begin
         eng_cnt <= eng_cnt - 1;
         if (eng_cnt == 1) begin
            op_done     <= 1'b1;
            op_ack_n    <= nack_map[cur_idx];
            op_arb_lost <= arb_map[cur_idx];
            op_rdata    <= 8'hC0 ^ cur_idx[7:0];
         end
      end else if (op_valid && !op_done) begin
         olog[nops] <= {op_code, op_byte, op_nack};
         cur_idx    <= nops;
         nops       <= nops + 1;
         eng_cnt    <= 2;
      end
      if (rx_push) begin
         rxlog[rx_cnt] <= rx_data;
         rx_cnt        <= rx_cnt + 1;
      end
   end

   int total = 0, fails = 0;
   logic [11:0] eo [0:15];

   function automatic logic [11:0] mk(input logic [2:0] c, input logic [7:0] b, input logic n);
      return {c, b, n};
   endfunction
   function automatic logic [10:0] cw(input logic frs, input logic stp, input logic rd, input logic [7:0] d);
      return {frs, stp, rd, d};
   endfunction
   function automatic logic [12:0] cfg(input logic ten, input logic spc, input logic sel, input logic [9:0] a);
      return {ten, spc, sel, a};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cmp_ops(input string req, input int base, input int n);
      chk({req, " op count"}, nops - base, n);
      for (int k = 0; k < n; k++) chk({req, " op"}, olog[base + k], eo[k]);
   endtask

   task automatic push(input logic [10:0] w);
      q[q_tail[3:0]] = w;
      q_tail = q_tail + 5'd1;
   endtask

   task automatic settle();
      repeat (80) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_abort();
      abort_clr = 1'b1;
      @(negedge clk);
      abort_clr = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 op_valid", op_valid, 0);
      chk("R1 cause", abort_cause, 0);
      chk("R1 flush", cmd_flush, 0);
      chk("R1 pend", abort_pend, 0);
   endtask

   task automatic t_basic_write();
      int b = nops;
      tgt_cfg = cfg(0, 0, 0, 10'h055);
      push(cw(0, 0, 0, 8'h11));
      push(cw(0, 1, 0, 8'h22));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hAA, 0);
      eo[2] = mk(C_WR, 8'h11, 0); eo[3] = mk(C_WR, 8'h22, 0); eo[4] = mk(C_STOP, 0, 0);
      cmp_ops("R2 R3 same-direction stream", b, 5);
      b = nops;
      push(cw(0, 1, 0, 8'h33));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hAA, 0);
      eo[2] = mk(C_WR, 8'h33, 0); eo[3] = mk(C_STOP, 0, 0);
      cmp_ops("R5 start after stop", b, 4);
   endtask

   task automatic t_dir_change();
      int b = nops;
      int r0 = rx_cnt;
      push(cw(0, 0, 0, 8'h44));
      push(cw(0, 0, 1, 8'h00));
      push(cw(0, 1, 1, 8'h00));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hAA, 0); eo[2] = mk(C_WR, 8'h44, 0);
      eo[3] = mk(C_RS, 0, 0); eo[4] = mk(C_WR, 8'hAB, 0);
      eo[5] = mk(C_RD, 0, 0); eo[6] = mk(C_RD, 0, 1); eo[7] = mk(C_STOP, 0, 0);
      cmp_ops("R4 R6 write then read", b, 8);
      chk("R6 rx count", rx_cnt - r0, 2);
      chk("R6 rx byte0", rxlog[r0], 8'hC0 ^ 8'(b + 5));
      chk("R6 rx byte1", rxlog[r0 + 1], 8'hC0 ^ 8'(b + 6));
      b = nops;
      push(cw(0, 0, 0, 8'h01));
      push(cw(1, 1, 0, 8'h02));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hAA, 0); eo[2] = mk(C_WR, 8'h01, 0);
      eo[3] = mk(C_RS, 0, 0); eo[4] = mk(C_WR, 8'hAA, 0); eo[5] = mk(C_WR, 8'h02, 0);
      eo[6] = mk(C_STOP, 0, 0);
      cmp_ops("R4 forced restart", b, 7);
   endtask

   task automatic t_ten_bit();
      int b = nops;
      tgt_cfg = cfg(1, 0, 0, 10'h2A5);
      push(cw(0, 1, 0, 8'h10));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hF4, 0); eo[2] = mk(C_WR, 8'hA5, 0);
      eo[3] = mk(C_WR, 8'h10, 0); eo[4] = mk(C_STOP, 0, 0);
      cmp_ops("R7 10-bit write", b, 5);
      b = nops;
      push(cw(0, 1, 1, 8'h00));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hF4, 0); eo[2] = mk(C_WR, 8'hA5, 0);
      eo[3] = mk(C_RS, 0, 0); eo[4] = mk(C_WR, 8'hF5, 0); eo[5] = mk(C_RD, 0, 1);
      eo[6] = mk(C_STOP, 0, 0);
      cmp_ops("R7 10-bit read", b, 7);
   endtask

   task automatic t_gen_call();
      int b = nops;
      tgt_cfg = cfg(0, 1, 0, 10'h055);
      push(cw(0, 1, 0, 8'h77));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'h00, 0);
      eo[2] = mk(C_WR, 8'h77, 0); eo[3] = mk(C_STOP, 0, 0);
      cmp_ops("R8 general call write", b, 4);
      b = nops;
      push(cw(0, 1, 1, 8'h00));
      settle();
      cmp_ops("R8 general call read", b, 0);
      chk("R8 cause", abort_cause, 17'h00010);
      chk("R11 flush held", cmd_flush, 1);
      clear_abort();
      chk("R11 cleared", abort_cause, 0);
   endtask

   task automatic t_start_byte();
      int b = nops;
      tgt_cfg = cfg(0, 1, 1, 10'h055);
      nack_map[b + 1] = 1'b1;
      push(cw(0, 1, 0, 8'h12));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'h01, 0); eo[2] = mk(C_RS, 0, 0);
      eo[3] = mk(C_WR, 8'hAA, 0); eo[4] = mk(C_WR, 8'h12, 0); eo[5] = mk(C_STOP, 0, 0);
      cmp_ops("R9 start byte", b, 6);
      b = nops;
      push(cw(0, 1, 0, 8'h13));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'h01, 0); eo[2] = mk(C_STOP, 0, 0);
      cmp_ops("R9 acked start byte", b, 3);
      chk("R9 cause", abort_cause, 17'h00080);
      clear_abort();
   endtask

   task automatic t_no_restart();
      int b = nops;
      restart_en = 1'b0;
      tgt_cfg = cfg(0, 0, 0, 10'h055);
      push(cw(0, 0, 0, 8'h01));
      push(cw(0, 1, 1, 8'h00));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hAA, 0);
      eo[2] = mk(C_WR, 8'h01, 0); eo[3] = mk(C_STOP, 0, 0);
      cmp_ops("R10 direction change", b, 4);
      chk("R10 dir cause", abort_cause, 17'h00800);
      clear_abort();
      b = nops;
      tgt_cfg = cfg(1, 0, 0, 10'h2A5);
      push(cw(0, 1, 1, 8'h00));
      settle();
      cmp_ops("R10 10-bit read", b, 0);
      chk("R10 10-bit cause", abort_cause, 17'h00400);
      clear_abort();
      b = nops;
      tgt_cfg = cfg(0, 1, 1, 10'h055);
      push(cw(0, 1, 0, 8'h05));
      settle();
      cmp_ops("R10 start byte", b, 0);
      chk("R10 start byte cause", abort_cause, 17'h00200);
      clear_abort();
      restart_en = 1'b1;
   endtask

   task automatic t_nacks();
      int b = nops;
      tgt_cfg = cfg(0, 0, 0, 10'h055);
      nack_map[b + 1] = 1'b1;
      push(cw(0, 1, 0, 8'h05));
      push(cw(0, 1, 0, 8'h06));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hAA, 0); eo[2] = mk(C_STOP, 0, 0);
      cmp_ops("R11 address nack", b, 3);
      chk("R11 addr7 cause", abort_cause, 17'h00001);
      chk("R11 queue flushed", cmd_avail, 0);
      clear_abort();
      b = nops;
      nack_map[b + 2] = 1'b1;
      push(cw(0, 1, 0, 8'h07));
      settle();
      chk("R11 data cause", abort_cause, 17'h00008);
      chk("R11 data stop", olog[b + 3], mk(C_STOP, 0, 0));
      clear_abort();
      b = nops;
      tgt_cfg = cfg(1, 0, 0, 10'h2A5);
      nack_map[b + 1] = 1'b1;
      push(cw(0, 1, 0, 8'h08));
      settle();
      chk("R11 ten1 cause", abort_cause, 17'h00002);
      clear_abort();
      b = nops;
      nack_map[b + 2] = 1'b1;
      push(cw(0, 1, 0, 8'h08));
      settle();
      chk("R11 ten2 cause", abort_cause, 17'h00004);
      chk("R11 ten2 ops", nops - b, 4);
      clear_abort();
      b = nops;
      tgt_cfg = cfg(0, 1, 0, 10'h055);
      nack_map[b + 1] = 1'b1;
      push(cw(0, 1, 0, 8'h08));
      settle();
      chk("R11 general call cause", abort_cause, 17'h00020);
      clear_abort();
   endtask

   task automatic t_arb();
      int b = nops;
      tgt_cfg = cfg(0, 0, 0, 10'h055);
      arb_map[b + 1] = 1'b1;
      push(cw(0, 1, 0, 8'h09));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hAA, 0);
      cmp_ops("R12 arbitration lost no stop", b, 2);
      chk("R12 cause", abort_cause, 17'h01000);
      clear_abort();
      b = nops;
      push(cw(0, 1, 0, 8'h0A));
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hAA, 0);
      eo[2] = mk(C_WR, 8'h0A, 0); eo[3] = mk(C_STOP, 0, 0);
      cmp_ops("R12 restart with START", b, 4);
   endtask

   task automatic t_user_abort();
      int b;
      enable = 1'b0;
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      @(negedge clk);
      chk("R13 ignored while disabled", abort_pend, 0);
      enable = 1'b1;
      b = nops;
      push(cw(0, 0, 0, 8'h01));
      settle();
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      chk("R13 pending", abort_pend, 1);
      settle();
      eo[0] = mk(C_START, 0, 0); eo[1] = mk(C_WR, 8'hAA, 0);
      eo[2] = mk(C_WR, 8'h01, 0); eo[3] = mk(C_STOP, 0, 0);
      cmp_ops("R13 stop issued", b, 4);
      chk("R13 cause", abort_cause, 17'h10000);
      chk("R13 pend cleared", abort_pend, 0);
      clear_abort();
   endtask

   logic finished = 1'b0;

   initial begin
      for (int i = 0; i < 256; i++) begin
         nack_map[i] = 1'b0;
         arb_map[i]  = 1'b0;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_write();
      t_dir_change();
      t_ten_bit();
      t_gen_call();
      t_start_byte();
      t_no_restart();
      t_nacks();
      t_arb();
      t_user_abort();
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule